// File: doc/BRIEF.md
# Monitor Channel Byte Handshake

This block carries multi-byte register messages over the monitor byte of one backplane time slot. The slot transceiver gives it one strobe per frame. On that strobe the block takes the monitor byte and the two handshake flags received in the current frame. In the same cycle it sets the monitor byte and the two flags to be sent in the next frame. The two flags are E, which marks that a byte is being sent, and A, which acknowledges a byte that was received. Both flags are active low. Both directions follow the same rules. So the block holds an independent sender and receiver side by side, and each of them drives its own flag.

Outgoing bytes enter through a valid/ready stream. A one-entry holding register sits behind `s_ready`. The stream accepts a byte on any cycle where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the sender has moved that byte onto the line at a frame strobe. The upstream logic must hold `s_valid`, `s_data` and `s_last` steady while `s_ready` is low. `s_last` marks the final byte of a message. A received byte is validated only when it arrives identical in two consecutive frames. It is then presented for one cycle on `m_valid`/`m_data`. This output has no back-pressure. A one-cycle `m_eom` pulse marks the end of a received message.

Top module: `mon_handshake`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, the outputs are `tx_mon` = all ones, `tx_e_n` = 1, `tx_a_n` = 1, `m_valid` = 0, `m_eom` = 0 and `s_ready` = 1. Any byte that was in progress or held is discarded.
- R2: The receiver is armed after reset and after every strobe with `rx_e_n` = 1. At a strobe where `rx_e_n` = 0 in both the current and the previous frame, with an identical `rx_mon` in both, an armed receiver delivers the byte. It raises `m_valid` for exactly the cycle after that strobe, with `m_data` = `rx_mon`.
- R3: If two consecutive E-active frames carry different bytes, nothing is delivered. The receiver waits for a new pair of matching frames.
- R4: `tx_a_n` goes to 0 at the delivering strobe. It stays 0 while `rx_e_n` stays 0, and the held byte is not delivered a second time. `tx_a_n` returns to 1 at the first strobe with `rx_e_n` = 1.
- R5: `m_eom` pulses for one cycle at the strobe that completes EOM_FRAMES (default 2) consecutive frames with `rx_e_n` = 1. It pulses only if a byte was delivered since the previous end-of-message or reset. A single E-inactive frame between bytes is not an end.
- R6: `s_ready` goes low in the cycle after a byte is accepted. It returns high after the strobe that moves that byte onto the line.
- R7: The sender starts a byte at a strobe where it is idle with no gap frames left, a byte is held and `rx_a_n` = 1. After that strobe, `tx_mon` = the byte and `tx_e_n` = 0. While no byte is being sent, `tx_e_n` = 1 and `tx_mon` = all ones.
- R8: The sender holds the same byte with `tx_e_n` = 0 through every strobe with `rx_a_n` = 1. At the first strobe with `rx_a_n` = 0, it returns to `tx_e_n` = 1 and `tx_mon` = all ones.
- R9: After an acknowledged byte, the sender keeps E inactive for at least 1 frame if the byte was not last, and for at least EOM_FRAMES frames if it was last. It starts the next byte only at a strobe with `rx_a_n` = 1.
- R10: `tx_mon`, `tx_e_n` and `tx_a_n` change only in the cycle after a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per frame from the slot transceiver |
| rx_mon | input | DATA_W | Monitor byte received in the current frame |
| rx_e_n | input | 1 | Received E flag, active low |
| rx_a_n | input | 1 | Received A flag, active low |
| tx_mon | output | DATA_W | Monitor byte to send in the next frame |
| tx_e_n | output | 1 | E flag to send, active low |
| tx_a_n | output | 1 | A flag to send, active low |
| s_valid | input | 1 | Outgoing byte valid |
| s_data | input | DATA_W | Outgoing byte |
| s_last | input | 1 | Outgoing byte ends the message |
| s_ready | output | 1 | Holding register empty, byte may be accepted |
| m_valid | output | 1 | One-cycle pulse, validated received byte |
| m_data | output | DATA_W | Validated received byte |
| m_eom | output | 1 | One-cycle pulse, received message ended |

## Verification
The sender and the receiver share one strobe. So a single strobe can deliver a received byte and also retire the outgoing byte because the peer's A is active. The bench provokes this case directly. It puts a byte on the line, then feeds the second matching frame of an incoming byte with `rx_a_n` = 0 in that same frame. After that strobe it expects `m_valid` with the incoming byte, `tx_a_n` = 0, and the sender back at E inactive with all ones. Random receive traffic is judged frame by frame against a bench reference model of R2 to R5.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  typedef enum logic {
    TX_WAIT = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/mon_tx_buf.sv
// One-entry holding register between the stream input and the sender.
module mon_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              pop,
  output logic              buf_valid,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_last
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (s_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= s_data;
      last_q <= s_last;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  assign s_ready   = !full_q;
  assign buf_valid = full_q;
  assign buf_data  = data_q;
  assign buf_last  = last_q;
endmodule

// File: rtl/mon_tx_fsm.sv
// Sender: holds a byte with E active until A is seen, then inserts gap frames.
module mon_tx_fsm
  import mon_hs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              rx_a_n,
  input  logic              buf_valid,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_last,
  output logic              pop,
  output logic [DATA_W-1:0] tx_mon,
  output logic              tx_e_n
);
  localparam int GW = $clog2(EOM_FRAMES + 1);
  localparam logic [GW-1:0] END_GAP = GW'(EOM_FRAMES - 1);

  tx_state_e   state_q;
  logic [GW-1:0] gap_left_q;
  logic        cur_last_q;

  assign pop = frame_stb && (state_q == TX_WAIT) && (gap_left_q == '0)
               && rx_a_n && buf_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TX_WAIT;
      gap_left_q <= '0;
      cur_last_q <= 1'b0;
      tx_mon     <= '1;
      tx_e_n     <= 1'b1;
    end else if (frame_stb) begin
      case (state_q)
        TX_WAIT: begin
          if (gap_left_q != '0) begin
            gap_left_q <= gap_left_q - 1'b1;
          end else if (pop) begin
            state_q    <= TX_SEND;
            tx_mon     <= buf_data;
            tx_e_n     <= 1'b0;
            cur_last_q <= buf_last;
          end
        end
        TX_SEND: begin
          if (!rx_a_n) begin
            state_q    <= TX_WAIT;
            tx_mon     <= '1;
            tx_e_n     <= 1'b1;
            gap_left_q <= cur_last_q ? END_GAP : '0;
          end
        end
        default: state_q <= TX_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/mon_rx_fsm.sv
// Receiver: double-frame validation, acknowledge, end-of-message detection.
module mon_rx_fsm #(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] rx_mon,
  input  logic              rx_e_n,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_eom,
  output logic              tx_a_n
);
  localparam int GW = $clog2(EOM_FRAMES + 1);
  localparam logic [GW-1:0] IDLE_MAX = GW'(EOM_FRAMES - 1);

  logic              prev_e_q;
  logic [DATA_W-1:0] prev_mon_q;
  logic              armed_q;
  logic              in_msg_q;
  logic [GW-1:0]     idle_cnt_q;
  logic              e_act;
  logic              match;

  assign e_act = !rx_e_n;
  assign match = e_act && prev_e_q && (rx_mon == prev_mon_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_e_q   <= 1'b0;
      prev_mon_q <= '1;
      armed_q    <= 1'b1;
      in_msg_q   <= 1'b0;
      idle_cnt_q <= '0;
      tx_a_n     <= 1'b1;
      m_valid    <= 1'b0;
      m_data     <= '0;
      m_eom      <= 1'b0;
    end else begin
      m_valid <= 1'b0;
      m_eom   <= 1'b0;
      if (frame_stb) begin
        prev_e_q   <= e_act;
        prev_mon_q <= rx_mon;
        if (e_act) begin
          idle_cnt_q <= '0;
          if (match && armed_q) begin
            m_valid  <= 1'b1;
            m_data   <= rx_mon;
            tx_a_n   <= 1'b0;
            armed_q  <= 1'b0;
            in_msg_q <= 1'b1;
          end
        end else begin
          tx_a_n  <= 1'b1;
          armed_q <= 1'b1;
          if (idle_cnt_q != IDLE_MAX) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
          end
          if ((idle_cnt_q == IDLE_MAX) && in_msg_q) begin
            m_eom    <= 1'b1;
            in_msg_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mon_handshake.sv
module mon_handshake #(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] rx_mon,
  input  logic              rx_e_n,
  input  logic              rx_a_n,
  output logic [DATA_W-1:0] tx_mon,
  output logic              tx_e_n,
  output logic              tx_a_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_eom
);
  logic              pop;
  logic              buf_valid;
  logic [DATA_W-1:0] buf_data;
  logic              buf_last;

  mon_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .pop(pop), .buf_valid(buf_valid), .buf_data(buf_data), .buf_last(buf_last)
  );

  mon_tx_fsm #(.DATA_W(DATA_W), .EOM_FRAMES(EOM_FRAMES)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_a_n(rx_a_n),
    .buf_valid(buf_valid), .buf_data(buf_data), .buf_last(buf_last),
    .pop(pop), .tx_mon(tx_mon), .tx_e_n(tx_e_n)
  );

  mon_rx_fsm #(.DATA_W(DATA_W), .EOM_FRAMES(EOM_FRAMES)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .rx_mon(rx_mon), .rx_e_n(rx_e_n),
    .m_valid(m_valid), .m_data(m_data), .m_eom(m_eom), .tx_a_n(tx_a_n)
  );
endmodule

// File: rtl/mon_handshake_chk.sv
module mon_handshake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              rx_e_n,
  input logic              rx_a_n,
  input logic [DATA_W-1:0] tx_mon,
  input logic              tx_e_n,
  input logic              tx_a_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_eom
);
  a_r10_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(tx_mon) && $stable(tx_e_n) && $stable(tx_a_n)));

  a_r2_valid_after_e_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ($past(frame_stb) && !$past(rx_e_n)));

  a_r4_ack_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !tx_a_n);

  a_r5_eom_after_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    m_eom |-> ($past(frame_stb) && $past(rx_e_n) && !m_valid));

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r7_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    tx_e_n |-> (tx_mon == '1));

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_e_n && frame_stb && rx_a_n) |=> (!tx_e_n && $stable(tx_mon)));
endmodule

bind mon_handshake mon_handshake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_e_n(rx_e_n),
  .rx_a_n(rx_a_n), .tx_mon(tx_mon), .tx_e_n(tx_e_n), .tx_a_n(tx_a_n),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid), .m_eom(m_eom)
);

// File: tb/mon_handshake_tb.sv
module mon_handshake_tb;
  localparam int DW  = 8;
  localparam int EOM = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_stb = 1'b0;
  logic [DW-1:0] rx_mon = '1;
  logic          rx_e_n = 1'b1;
  logic          rx_a_n = 1'b1;
  logic [DW-1:0] tx_mon;
  logic          tx_e_n, tx_a_n;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic          s_ready, m_valid, m_eom;
  logic [DW-1:0] m_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model of the receiver (R2..R5)
  bit          rm_prev_e, rm_armed, rm_inmsg, rm_a_n;
  logic [7:0]  rm_prev_mon;
  int          rm_idle;
  bit          ex_valid, ex_eom;
  logic [7:0]  ex_data;

  mon_handshake #(.DATA_W(DW), .EOM_FRAMES(EOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_mon(rx_mon),
    .rx_e_n(rx_e_n), .rx_a_n(rx_a_n), .tx_mon(tx_mon), .tx_e_n(tx_e_n),
    .tx_a_n(tx_a_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data), .m_eom(m_eom)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rm_reset();
    rm_prev_e = 0; rm_prev_mon = 8'hFF; rm_armed = 1; rm_inmsg = 0;
    rm_idle = 0; rm_a_n = 1;
  endtask

  task automatic rm_step(input logic [7:0] mon, input bit e_n);
    ex_valid = 0; ex_eom = 0;
    if (!e_n) begin
      rm_idle = 0;
      if (rm_prev_e && mon == rm_prev_mon && rm_armed) begin
        ex_valid = 1; ex_data = mon; rm_a_n = 0; rm_armed = 0; rm_inmsg = 1;
      end
    end else begin
      rm_a_n = 1; rm_armed = 1;
      if (rm_idle < EOM) rm_idle++;
      if (rm_idle == EOM && rm_inmsg) begin ex_eom = 1; rm_inmsg = 0; end
    end
    rm_prev_e = !e_n; rm_prev_mon = mon;
  endtask

  // one frame: strobe with the given received values, then check receiver side
  task automatic frame(input logic [7:0] mon, input bit e_n, input bit a_n);
    @(negedge clk);
    frame_stb = 1; rx_mon = mon; rx_e_n = e_n; rx_a_n = a_n;
    rm_step(mon, e_n);
    @(negedge clk);
    frame_stb = 0;
    chk(m_valid == ex_valid, "R2 m_valid", m_valid, ex_valid);
    if (ex_valid) chk(m_data == ex_data, "R2 m_data", m_data, ex_data);
    chk(m_eom == ex_eom, "R5 m_eom", m_eom, ex_eom);
    chk(tx_a_n == rm_a_n, "R4 tx_a_n", tx_a_n, rm_a_n);
    @(negedge clk);
    chk(m_valid == 0 && m_eom == 0, "R2 pulse width", {m_valid, m_eom}, 0);
  endtask

  task automatic push(input logic [7:0] d, input bit last);
    @(negedge clk);
    chk(s_ready == 1, "R6 ready before push", s_ready, 1);
    s_valid = 1; s_data = d; s_last = last;
    @(negedge clk);
    s_valid = 0;
    chk(s_ready == 0, "R6 ready after push", s_ready, 0);
  endtask

  task automatic tx_is(input bit e_n, input logic [7:0] mon, input string req);
    chk(tx_e_n == e_n, req, tx_e_n, e_n);
    chk(tx_mon == mon, req, tx_mon, mon);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c_0a7e));
    rm_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    tx_is(1, 8'hFF, "R1 tx idle");
    chk(tx_a_n == 1, "R1 tx_a_n", tx_a_n, 1);
    chk(s_ready == 1 && m_valid == 0 && m_eom == 0, "R1 flags",
        {s_ready, m_valid, m_eom}, 3'b100);

    // R2/R4/R5 directed receive
    frame(8'h5A, 0, 1);
    frame(8'h5A, 0, 1);
    frame(8'h5A, 0, 1);          // R4 held byte not delivered again
    frame(8'hFF, 1, 1);          // R5 single gap, no end
    frame(8'h6B, 0, 1);
    frame(8'h6B, 0, 1);
    frame(8'hFF, 1, 1);
    frame(8'hFF, 1, 1);          // R5 end of message
    // R3 mismatch
    frame(8'h11, 0, 1);
    frame(8'h22, 0, 1);
    frame(8'h22, 0, 1);
    frame(8'hFF, 1, 1);
    frame(8'hFF, 1, 1);

    // random receive traffic, sender must stay idle (R7)
    for (int i = 0; i < 400; i++) begin
      logic [7:0] m;
      bit en;
      case ($urandom % 4)
        0: m = 8'h3C;
        1: m = 8'hC3;
        default: m = 8'($urandom);
      endcase
      if ($urandom % 3 == 0) m = rx_mon;
      en = ($urandom % 4 == 0);
      frame(m, en, 1);
      tx_is(1, 8'hFF, "R7 idle without byte");
    end
    frame(8'hFF, 1, 1);
    frame(8'hFF, 1, 1);

    // transmit path
    push(8'hA1, 0);
    frame(8'hFF, 1, 1);
    tx_is(0, 8'hA1, "R7 start byte");
    chk(s_ready == 1, "R6 ready after pop", s_ready, 1);
    push(8'hB2, 1);
    frame(8'hFF, 1, 1);
    tx_is(0, 8'hA1, "R8 hold without ack");
    frame(8'hFF, 1, 0);
    tx_is(1, 8'hFF, "R8 release on ack");
    frame(8'hFF, 1, 0);
    tx_is(1, 8'hFF, "R9 wait for A inactive");
    chk(s_ready == 0, "R6 still held", s_ready, 0);
    frame(8'hFF, 1, 1);
    tx_is(0, 8'hB2, "R9 next byte after one gap");
    frame(8'hFF, 1, 0);
    tx_is(1, 8'hFF, "R8 last acked");
    push(8'hC3, 0);
    frame(8'hFF, 1, 1);
    tx_is(1, 8'hFF, "R9 end gap frame");
    frame(8'hFF, 1, 1);
    tx_is(0, 8'hC3, "R9 start after end gap");
    frame(8'hFF, 1, 0);
    tx_is(1, 8'hFF, "R8 acked");
    frame(8'hFF, 1, 1);

    // same strobe: receive delivery and transmit acknowledge
    push(8'h77, 1);
    frame(8'hFF, 1, 1);
    tx_is(0, 8'h77, "R7 start 77");
    frame(8'h44, 0, 1);
    tx_is(0, 8'h77, "R8 hold 77");
    frame(8'h44, 0, 0);
    tx_is(1, 8'hFF, "R8 retire with delivery");
    frame(8'hFF, 1, 1);
    frame(8'hFF, 1, 1);
    frame(8'hFF, 1, 1);

    // reset in the middle of a transfer
    push(8'h99, 0);
    frame(8'hFF, 1, 1);
    tx_is(0, 8'h99, "R7 start 99");
    push(8'hAA, 0);
    frame(8'h55, 0, 1);
    frame(8'h55, 0, 1);
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rm_reset();
    @(negedge clk);
    tx_is(1, 8'hFF, "R1 mid-transfer reset");
    chk(tx_a_n == 1 && s_ready == 1, "R1 reset ack and buffer",
        {tx_a_n, s_ready}, 2'b11);
    frame(8'hFF, 1, 1);
    tx_is(1, 8'hFF, "R1 held byte discarded");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule